// File: doc/BRIEF.md
# Byte-to-Serial Transmit Timing Generator

This block is the last digital stage before a serial line driver. It takes 8-bit transmit bytes on an upstream byte clock and shifts them out one bit per serial bit clock. It also divides the bit clock by eight to give a byte-rate clock, which upstream logic is expected to use. The upstream clock may arrive at any phase relative to the internal load clock. A four-entry elastic FIFO with Gray-coded pointers moves each byte into the bit-clock domain. A load strobe, generated once every eight bit clocks, then places the byte in the shift register.

A rate-mode input picks the higher-rate (622.08 Mbit/s) or lower-rate (155.52 Mbit/s) line setting, and a two-bit reference-select input names the reference frequency. From these two inputs the block reports the multiplier that the external synthesizer must apply. It flags the one combination that is not allowed. Two loopback controls are provided. Diagnostic loopback sends the transmit serial stream into the receive path. Line loopback sends the received serial stream back out on the transmit output.

Top module: `tx_ser_top`

## Requirements
- R1: `byte_clk_o` is the bit clock divided by 8: high for 4 bit clocks and low for 4. Each falling edge of `byte_clk_o` coincides with the load of a new byte into the shift register.
- R2: Bytes leave on `ser_o` most significant bit first, one bit per bit clock, in the order they were written on `up_clk_i`.
- R3: `mult_o` reports the reference multiplier. With `mode_i`=1 it is 32, 16, 12 or 8 for `refsel_i` = 0, 1, 2 or 3. With `mode_i`=0 it is 8, 4 or 3 for `refsel_i` = 0, 1 or 2. Reference codes 0..3 mean 19.44, 38.88, 51.84 and 77.76 MHz.
- R4: `cfg_err_o` is 1 exactly when `mode_i`=0 and `refsel_i`=3. In that case `mult_o` is 0.
- R5: An upstream clock of the byte rate, at any fixed phase, moves data through without loss and without raising `fifo_err_o`. Reading starts once the FIFO holds one entry.
- R6: A write into a full FIFO (overflow) or a load from an empty, already started FIFO (underflow) sets `fifo_err_o`. The flag stays at 1 until `rst_ni` is asserted.
- R7: After reset, `ser_o` is 0 until the first byte has passed through the FIFO.
- R8: When `diag_lb_i`=1, `rx_path_o` carries the transmit serial stream. When `diag_lb_i`=0, it carries `rx_ser_i`.
- R9: When `line_lb_i`=1, `ser_o` carries `rx_ser_i` in place of the serialized bytes.
- R10: When both loopbacks are set, `ser_o` follows `rx_ser_i` (line loopback wins) and `rx_path_o` still carries the transmit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| up_clk_i | input | 1 | Upstream byte clock |
| data_i | input | 8 | Transmit byte, written on every `up_clk_i` rising edge |
| mode_i | input | 1 | 1 = 622.08 Mbit/s rate, 0 = 155.52 Mbit/s rate |
| refsel_i | input | 2 | Reference select: 0=19.44, 1=38.88, 2=51.84, 3=77.76 MHz |
| diag_lb_i | input | 1 | Diagnostic loopback enable |
| line_lb_i | input | 1 | Line loopback enable |
| rx_ser_i | input | 1 | Received serial data |
| ser_o | output | 1 | Transmit serial output |
| rx_path_o | output | 1 | Serial data into the receive path |
| byte_clk_o | output | 1 | Byte-rate clock, bit clock / 8 |
| mult_o | output | 6 | Reference multiplier for the synthesizer |
| cfg_err_o | output | 1 | Illegal mode/reference combination |
| fifo_err_o | output | 1 | Sticky FIFO overflow or underflow |

## Verification
The bench drives the upstream clock at two phases against the load strobe, one just after the byte clock rises and one just after a load. A crossing that samples pointers badly would lose, repeat or corrupt bytes there, or would raise a false error. Loopback controls change at byte boundaries while the stream is rebuilt from whichever output still carries it. A design with the wrong priority would put transmit data on `ser_o` when both loopbacks are set. A design that serialized LSB first, or loaded off the byte-clock edge, would show every byte as mismatched. A faster and then a slower upstream clock must set the error flag, and the flag must stay set until reset.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  localparam int unsigned MULT_W = 6;

  // Multiplier = line rate / reference frequency.
  function automatic logic [MULT_W-1:0] ref_mult(input logic hi_rate, input logic [1:0] rs);
    logic [MULT_W-1:0] m;
    if (hi_rate) begin
      case (rs)
        2'd0: m = 6'd32;
        2'd1: m = 6'd16;
        2'd2: m = 6'd12;
        default: m = 6'd8;
      endcase
    end else begin
      case (rs)
        2'd0: m = 6'd8;
        2'd1: m = 6'd4;
        2'd2: m = 6'd3;
        default: m = 6'd0;
      endcase
    end
    return m;
  endfunction

  function automatic logic ref_illegal(input logic hi_rate, input logic [1:0] rs);
    return !hi_rate && (rs == 2'd3);
  endfunction
endpackage

// File: rtl/tx_byte_div.sv
module tx_byte_div #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic byte_clk_o,
  output logic load_o
);
  localparam int unsigned CW = $clog2(DIV);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign byte_clk_o = cnt_q[CW-1];
  assign load_o     = (cnt_q == CW'(DIV - 1));

  p_load_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> $fell(byte_clk_o));
  p_load_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/tx_sync.sv
module tx_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tx_align_fifo.sv
module tx_align_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PRIME = 1
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o,
  output logic         err_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_s, wgray_s, rbin_s, wbin_s, level;
  logic          full, wr_en, ovf_q, udf_q, primed_q;

  // write domain
  tx_sync #(.W(PW)) u_sync_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_s));
  assign rbin_s = g2b(rgray_s);
  assign full   = ((wbin_q - rbin_s) == PW'(DEPTH));
  assign wr_en  = !full;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else if (wr_en) begin
      wbin_q  <= wbin_q + 1'b1;
      wgray_q <= b2g(wbin_q + 1'b1);
    end else begin
      ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr_en) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  // read domain
  tx_sync #(.W(PW)) u_sync_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_s));
  assign wbin_s = g2b(wgray_s);
  assign level  = wbin_s - rbin_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      primed_q <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      if (level >= PW'(PRIME)) primed_q <= 1'b1;
      if (rd_i && primed_q) begin
        if (level == '0) udf_q <= 1'b1;
        else begin
          rbin_q  <= rbin_q + 1'b1;
          rgray_q <= b2g(rbin_q + 1'b1);
        end
      end
    end
  end

  assign rdata_o  = mem[rbin_q[AW-1:0]];
  assign rvalid_o = primed_q && (level != '0);
  assign err_o    = ovf_q | udf_q;

  p_ovf_sticky_r6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  p_udf_sticky_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    udf_q |=> udf_q);
  p_read_advance_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_i && rvalid_o) |=> (rbin_q == $past(rbin_q) + 1'b1));
  p_no_overrun_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin_q - rbin_s) <= PW'(DEPTH));
endmodule

// File: rtl/tx_ser_top.sv
module tx_ser_top
  import tx_ser_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned PRIME  = 1
) (
  input  logic              bit_clk_i,
  input  logic              rst_ni,
  input  logic              up_clk_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              mode_i,
  input  logic [1:0]        refsel_i,
  input  logic              diag_lb_i,
  input  logic              line_lb_i,
  input  logic              rx_ser_i,
  output logic              ser_o,
  output logic              rx_path_o,
  output logic              byte_clk_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              cfg_err_o,
  output logic              fifo_err_o
);
  logic              load, rvalid, started_q, tx_bit;
  logic [BYTE_W-1:0] rdata, sh_q;

  tx_byte_div #(.DIV(BYTE_W)) u_div (
    .clk_i(bit_clk_i), .rst_ni(rst_ni), .byte_clk_o(byte_clk_o), .load_o(load)
  );

  tx_align_fifo #(.W(BYTE_W), .DEPTH(DEPTH), .PRIME(PRIME)) u_fifo (
    .wclk_i(up_clk_i), .rclk_i(bit_clk_i), .rst_ni(rst_ni), .wdata_i(data_i),
    .rd_i(load), .rdata_o(rdata), .rvalid_o(rvalid), .err_o(fifo_err_o)
  );

  // MSB-first shifter; underflow loads zeros
  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      started_q <= 1'b0;
    end else if (load) begin
      sh_q <= rvalid ? rdata : '0;
      if (rvalid) started_q <= 1'b1;
    end else begin
      sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign tx_bit    = sh_q[BYTE_W-1];
  assign ser_o     = line_lb_i ? rx_ser_i : tx_bit;
  assign rx_path_o = diag_lb_i ? tx_bit : rx_ser_i;

  assign mult_o    = ref_mult(mode_i, refsel_i);
  assign cfg_err_o = ref_illegal(mode_i, refsel_i);

  p_quiet_before_start_r7: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !started_q |-> !tx_bit);
  p_load_byte_r2: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (load && rvalid) |=> (sh_q == $past(rdata)));
  p_shift_r2: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !load |=> (sh_q[BYTE_W-1:1] == $past(sh_q[BYTE_W-2:0])));

  always_comb begin
    a_cfg_mult_r4: assert (!cfg_err_o || mult_o == '0);
  end
endmodule

// File: tb/tx_ser_top_tb.sv
module tx_ser_top_tb;
  logic       bit_clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       up_d1 = 1'b0, up_d2 = 1'b0, up_fast = 1'b0, up_slow = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       up_clk;
  logic [7:0] data;
  logic       mode = 1'b1, diag = 1'b0, line = 1'b0, rx = 1'b0;
  logic [1:0] refsel = 2'd0;
  logic       ser, rx_path, byte_clk, cfg_err, fifo_err;
  logic [5:0] mult;

  int checks = 0, fails = 0;
  logic [7:0] arr [256];
  logic [7:0] k;

  always #10ns bit_clk = ~bit_clk;
  always #50ns up_fast = ~up_fast;
  always #150ns up_slow = ~up_slow;
  always @(byte_clk) up_d1 <= #7ns byte_clk;
  always @(byte_clk) up_d2 <= #113ns byte_clk;

  assign up_clk = (clk_sel == 2'd0) ? up_d1 : (clk_sel == 2'd1) ? up_fast :
                  (clk_sel == 2'd2) ? up_slow : up_d2;

  always @(negedge up_clk or negedge rst_ni)
    if (!rst_ni) k <= 8'd0;
    else k <= k + 8'd1;
  assign data = arr[k];

  tx_ser_top u_dut (
    .bit_clk_i(bit_clk), .rst_ni(rst_ni), .up_clk_i(up_clk), .data_i(data),
    .mode_i(mode), .refsel_i(refsel), .diag_lb_i(diag), .line_lb_i(line),
    .rx_ser_i(rx), .ser_o(ser), .rx_path_o(rx_path), .byte_clk_o(byte_clk),
    .mult_o(mult), .cfg_err_o(cfg_err), .fifo_err_o(fifo_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // line rate and reference in units of 6.48 MHz
  function automatic int exp_mult(input bit m, input int rs);
    int rate, rf;
    rate = m ? 96 : 24;
    rf = (rs == 0) ? 3 : (rs == 1) ? 6 : (rs == 2) ? 8 : 12;
    if (!m && rs == 3) return 0;
    return rate / rf;
  endfunction

  // stream monitor
  bit   mon_en = 1'b0, started = 1'b0, prev_bc = 1'b0, byte_ok = 1'b0;
  int   bpos = 8, idx = 0, matched = 0, mism = 0;
  logic [7:0] acc = 8'd0;

  always @(negedge bit_clk) begin
    if (!rst_ni || !mon_en) begin
      started = 1'b0; bpos = 8; idx = 0; prev_bc = 1'b0;
    end else begin
      if (prev_bc && !byte_clk) begin bpos = 0; byte_ok = 1'b1; end
      prev_bc = byte_clk;
      acc = {acc[6:0], line ? rx_path : ser};
      if (line && !diag) byte_ok = 1'b0;
      if (bpos == 7) begin
        if (!started) begin
          if (acc != 8'd0) begin
            started = 1'b1;
            chk(acc == arr[0], "R7 first byte after zeros", acc, arr[0]);
            idx = 1;
          end
        end else begin
          if (byte_ok) begin
            if (acc == arr[idx[7:0]]) matched++;
            else mism++;
            chk(acc == arr[idx[7:0]], line ? "R10 tx stream on rx_path" : "R2 byte order",
                acc, arr[idx[7:0]]);
          end
          idx++;
        end
      end
      if (bpos < 8) bpos++;
    end
  end

  task automatic do_reset(input logic [1:0] sel);
    rst_ni = 1'b0;
    repeat (3) @(negedge bit_clk);
    clk_sel = sel;
    #400ns;
    @(negedge bit_clk);
    #3ns rst_ni = 1'b1;
  endtask

  task automatic at_boundary(input bit d, input bit l);
    @(negedge byte_clk);
    #1ns diag = d; line = l;
  endtask

  int wd = 0;
  always @(posedge bit_clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int highs, rises, bad;
    logic prev;
    void'($urandom(32'd20240611));
    arr[0] = 8'hA5;
    for (int i = 1; i < 256; i++) arr[i] = 8'($urandom);
    arr[1] = 8'h01; arr[2] = 8'h80; arr[3] = 8'hFF; arr[4] = 8'h00;

    // config table, combinational
    for (int m = 0; m < 2; m++)
      for (int rs = 0; rs < 4; rs++) begin
        mode = m[0]; refsel = rs[1:0];
        #1ns;
        chk(mult == 6'(exp_mult(m[0], rs)), "R3 multiplier", mult, exp_mult(m[0], rs));
        chk(cfg_err == (m == 0 && rs == 3), "R4 config error", cfg_err, (m == 0 && rs == 3));
      end
    mode = 1'b1; refsel = 2'd1;

    // phase A: upstream clock 7ns after byte clock
    do_reset(2'd0);
    mon_en = 1'b1;
    chk(fifo_err == 1'b0, "R6 reset clears flag", fifo_err, 0);
    chk(byte_clk == 1'b0, "R1 byte clock reset", byte_clk, 0);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge bit_clk);
      if (ser !== 1'b0) bad++;
    end
    chk(bad == 0, "R7 quiet after reset", bad, 0);

    highs = 0; rises = 0; prev = byte_clk;
    for (int i = 0; i < 64; i++) begin
      @(negedge bit_clk);
      if (byte_clk) highs++;
      if (byte_clk && !prev) rises++;
      prev = byte_clk;
    end
    chk(highs == 32, "R1 duty", highs, 32);
    chk(rises == 8, "R1 period", rises, 8);

    repeat (200) @(negedge bit_clk);
    chk(started, "R5 stream started", started, 1);

    // diagnostic loopback only
    at_boundary(1'b1, 1'b0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge bit_clk); rx = 1'($urandom); #2ns;
      if (rx_path !== ser) bad++;
    end
    chk(bad == 0, "R8 rx_path follows tx", bad, 0);

    // line loopback only
    at_boundary(1'b0, 1'b1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge bit_clk); rx = 1'($urandom); #2ns;
      if (ser !== rx) bad++;
      if (rx_path !== rx) bad++;
    end
    chk(bad == 0, "R9 ser follows rx, R8 rx_path follows rx", bad, 0);

    // both loopbacks
    at_boundary(1'b1, 1'b1);
    bad = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge bit_clk); rx = 1'($urandom); #2ns;
      if (ser !== rx) bad++;
    end
    chk(bad == 0, "R10 line loopback priority", bad, 0);

    at_boundary(1'b0, 1'b0);
    repeat (80) @(negedge bit_clk);
    chk(mism == 0 && matched > 40, "R2 stream intact", mism, 0);
    chk(fifo_err == 1'b0, "R5 no error at phase 7ns", fifo_err, 0);

    // phase B: upstream clock 113ns after byte clock
    mon_en = 1'b0;
    do_reset(2'd3);
    mon_en = 1'b1;
    matched = 0;
    repeat (400) @(negedge bit_clk);
    chk(started && mism == 0 && matched > 30, "R5 stream intact at phase 113ns", matched, 31);
    chk(fifo_err == 1'b0, "R5 no error at phase 113ns", fifo_err, 0);

    // overflow: faster upstream clock
    mon_en = 1'b0;
    do_reset(2'd1);
    repeat (400) @(negedge bit_clk);
    chk(fifo_err == 1'b1, "R6 overflow flagged", fifo_err, 1);
    repeat (100) @(negedge bit_clk);
    chk(fifo_err == 1'b1, "R6 flag sticky", fifo_err, 1);
    rst_ni = 1'b0;
    #5ns;
    chk(fifo_err == 1'b0, "R6 reset clears overflow", fifo_err, 0);

    // underflow: slower upstream clock
    do_reset(2'd2);
    repeat (400) @(negedge bit_clk);
    chk(fifo_err == 1'b1, "R6 underflow flagged", fifo_err, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule